// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block takes single read and write requests from the inside of the chip and runs them as cycles on an asynchronous static-memory bus. The bus has six regions, and each has its own active-low chip select. Each region is configured on its own in four ways: its device kind (non-burst ROM or flash, SRAM, or variable-latency I/O), its data width (16 or 32 bits), its strobe length in memory clocks and its recovery gap in memory clocks.

A request is held on a valid/ready handshake and carries a region number, a 26-bit byte address, an access size, write data and a direction flag. The controller drives the chip select and address for one clock. It then pulses the correct strobe for the programmed length. A variable-latency I/O device can hold the strobe longer by keeping its ready line low. The controller then signals completion and returns the read data. Byte-lane enables are active low. They are derived from the size and the low address bits on writes, and all four are forced to zero on reads. Writes to variable-latency I/O use their own write strobe, so the normal write strobe stays free for other work.

Top module: `static_mem_ctrl`

## Requirements
- R1: While reset is held, all six chip selects, the output enable and both write strobes are high, and req_ready is low.
- R2: A request seen in idle gives this sequence. First comes one setup clock with the chip select low and no strobe. Next come strobe clocks, cfg_strobe+1 of them plus any wait clocks. Then comes one done clock with req_ready high and every chip select high. Last come cfg_recov further clocks with the bus idle before the next request can be accepted.
- R3: During setup and strobe, exactly one chip select is low: bit req_cs of mem_cs_n. At every other time, all chip selects are high.
- R4: On a read, mem_oe_n is low for the strobe clocks, whatever the region kind. Both write strobes stay high.
- R5: On a write, mem_we_n is the strobe for kinds 0 (ROM/flash), 1 (SRAM) and 3 (treated as SRAM). mem_pwe_n is the strobe for kind 2 (variable-latency I/O). mem_oe_n stays high.
- R6: For a kind-2 region, once the strobe count has run out, the strobe is held one more clock for each clock in which mem_rdy is low. For any other kind, mem_rdy has no effect on the cycle length.
- R7: On reads, mem_be_n is 0000. mem_addr has bits [1:0] forced to 0 in a 32-bit region, and bit 0 forced to 0 in a 16-bit region. The higher bits pass through unchanged.
- R8: On writes to a 32-bit region, mem_addr equals req_addr. For mem_be_n, size 0 (byte) drives bit addr[1:0] low and the others high. Size 1 (halfword) drives 1100 when addr[1]=0 and 0011 when addr[1]=1. Sizes 2 and 3 (word) drive 0000.
- R9: On writes to a 16-bit region, mem_be_n[3:2] is 11. Size 0 drives mem_be_n[1:0] to 10 when addr[0]=0 and to 01 when addr[0]=1. Any larger size drives 00.
- R10: Read data is sampled on the clock edge that ends the strobe. It appears on rsp_rdata from the done clock onward. In a 16-bit region, the upper 16 bits are 0.
- R11: During the setup and strobe clocks of a write, mem_wdata_en is high and mem_wdata equals the request's write data. At all other times, mem_wdata_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset |
| cfg_kind | input | 12 | Two bits per region: 0 ROM/flash, 1 SRAM, 2 variable-latency I/O, 3 SRAM |
| cfg_wide | input | 6 | One bit per region: 1 = 32-bit, 0 = 16-bit |
| cfg_strobe | input | 24 | Four bits per region: strobe clocks minus one |
| cfg_recov | input | 24 | Four bits per region: recovery clocks after the done clock |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request complete (one clock) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Region number, 0 to 5 |
| req_addr | input | 26 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_wdata | input | 32 | Write data, already placed on its lanes |
| rsp_rdata | output | 32 | Read data of the last read |
| mem_cs_n | output | 6 | Chip selects, active low |
| mem_addr | output | 26 | Bus byte address |
| mem_be_n | output | 4 | Byte-lane enables, active low; bit 3 is the top byte |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe for ROM/flash and SRAM, active low |
| mem_pwe_n | output | 1 | Write strobe for variable-latency I/O, active low |
| mem_wdata | output | 32 | Bus write data |
| mem_wdata_en | output | 1 | Bus data driver enable |
| mem_rdata | input | 32 | Bus read data |
| mem_rdy | input | 1 | Ready from variable-latency I/O devices |

## Verification
The four write byte offsets and the two halfword offsets are each tried in a 32-bit region, and a word write as well, to tell lane selection apart from address pass-through. The same sizes are repeated in a 16-bit region to show that only the low two lanes are used. Reads use addresses with the low bits set, so that forcing those bits to zero is visible. Variable-latency I/O reads and writes are run with mem_rdy held low past the end of the strobe count, and a ROM region is run with mem_rdy low all the time. Together these show that wait states are added only for the one kind. Regions with zero strobe and zero recovery are run back to back to check the shortest cycle and the gap between requests.

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl #(
  parameter int NCS = 6,
  parameter int AW  = 26,
  parameter int CW  = 4,
  localparam int CSW = $clog2(NCS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*NCS-1:0]  cfg_kind,
  input  logic [NCS-1:0]    cfg_wide,
  input  logic [CW*NCS-1:0] cfg_strobe,
  input  logic [CW*NCS-1:0] cfg_recov,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic [31:0]       rsp_rdata,
  output logic [NCS-1:0]    mem_cs_n,
  output logic [AW-1:0]     mem_addr,
  output logic [3:0]        mem_be_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_pwe_n,
  output logic [31:0]       mem_wdata,
  output logic              mem_wdata_en,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rdy
);
  localparam logic [1:0] KIND_VLIO = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STROBE, S_DONE, S_RECOV} state_t;
  state_t state;

  logic [CSW-1:0] r_cs;
  logic [AW-1:0]  r_addr;
  logic [1:0]     r_size;
  logic           r_wr;
  logic [31:0]    r_wdata;
  logic [CW-1:0]  cnt;

  logic [1:0]    kind;
  logic          wide;
  logic [CW-1:0] stb_len, rcv_len;

  always_comb begin
    kind = 2'd0; wide = 1'b1; stb_len = '0; rcv_len = '0;
    for (int i = 0; i < NCS; i++) begin
      if (r_cs == CSW'(i)) begin
        kind    = cfg_kind[2*i +: 2];
        wide    = cfg_wide[i];
        stb_len = cfg_strobe[CW*i +: CW];
        rcv_len = cfg_recov[CW*i +: CW];
      end
    end
  end

  wire busy   = (state == S_SETUP) || (state == S_STROBE);
  wire strobe = (state == S_STROBE);
  wire vlio   = (kind == KIND_VLIO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      r_cs      <= '0;
      r_addr    <= '0;
      r_size    <= '0;
      r_wr      <= 1'b0;
      r_wdata   <= '0;
      cnt       <= '0;
      rsp_rdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          r_cs    <= req_cs;
          r_addr  <= req_addr;
          r_size  <= req_size;
          r_wr    <= req_write;
          r_wdata <= req_wdata;
          state   <= S_SETUP;
        end
        S_SETUP: begin
          cnt   <= stb_len;
          state <= S_STROBE;
        end
        S_STROBE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (!vlio || mem_rdy) begin
            if (!r_wr) rsp_rdata <= wide ? mem_rdata : {16'h0, mem_rdata[15:0]};
            state <= S_DONE;
          end
        end
        S_DONE: begin
          cnt   <= rcv_len;
          state <= (rcv_len == '0) ? S_IDLE : S_RECOV;
        end
        S_RECOV: begin
          if (cnt <= 1) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign mem_cs_n[g] = !(busy && r_cs == CSW'(g));
  end

  assign req_ready    = (state == S_DONE);
  assign mem_oe_n     = !(strobe && !r_wr);
  assign mem_we_n     = !(strobe && r_wr && !vlio);
  assign mem_pwe_n    = !(strobe && r_wr && vlio);
  assign mem_wdata    = r_wdata;
  assign mem_wdata_en = busy && r_wr;

  always_comb begin
    mem_addr = r_addr;
    mem_be_n = 4'b0000;
    if (!r_wr) begin
      mem_addr[0] = 1'b0;
      if (wide) mem_addr[1] = 1'b0;
    end else if (wide) begin
      case (r_size)
        2'd0:    mem_be_n = ~(4'b0001 << r_addr[1:0]);
        2'd1:    mem_be_n = r_addr[1] ? 4'b0011 : 4'b1100;
        default: mem_be_n = 4'b0000;
      endcase
    end else begin
      mem_be_n[3:2] = 2'b11;
      if (r_size == 2'd0) mem_be_n[1:0] = r_addr[0] ? 2'b01 : 2'b10;
    end
  end
endmodule

module static_mem_ctrl_chk #(
  parameter int NCS = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] mem_cs_n,
  input logic [3:0]     mem_be_n,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic           mem_pwe_n,
  input logic           mem_rdy,
  input logic           req_ready
);
  wire any_strobe = !mem_oe_n || !mem_we_n || !mem_pwe_n;

  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> (~mem_cs_n != '0));

  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_oe_n, mem_we_n, mem_pwe_n}) >= 2);

  p_ready_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ($past(any_strobe) && (~mem_cs_n == '0)));

  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  p_read_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_be_n == 4'b0000));

  p_vlio_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_pwe_n && !mem_rdy) |=> !mem_pwe_n);
endmodule

bind static_mem_ctrl static_mem_ctrl_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_cs_n(mem_cs_n), .mem_be_n(mem_be_n),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_pwe_n(mem_pwe_n),
  .mem_rdy(mem_rdy), .req_ready(req_ready)
);

// File: tb/tb_static_mem_ctrl.sv
module tb_static_mem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_kind;
  logic [5:0]  cfg_wide;
  logic [23:0] cfg_strobe, cfg_recov;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [2:0]  req_cs = '0;
  logic [25:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0, rsp_rdata, mem_wdata, mem_rdata = '0;
  logic [5:0]  mem_cs_n;
  logic [25:0] mem_addr;
  logic [3:0]  mem_be_n;
  logic        mem_oe_n, mem_we_n, mem_pwe_n, mem_wdata_en;
  logic        mem_rdy = 1'b1;

  int total = 0, bad = 0, cycles = 0;
  int kind[6] = '{0, 1, 1, 2, 2, 1};
  int wide[6] = '{1, 1, 0, 1, 0, 1};
  int stb[6]  = '{1, 2, 0, 1, 0, 0};
  int rcv[6]  = '{0, 1, 2, 1, 0, 0};

  always #5 clk = ~clk;

  static_mem_ctrl dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_idle(input string tag, input bit rdy_exp);
    chk(mem_cs_n == 6'h3F, {tag, " R3 cs idle"}, 64'(mem_cs_n), 64'h3F);
    chk({mem_oe_n, mem_we_n, mem_pwe_n} == 3'b111, {tag, " R4/R5 strobes idle"},
        64'({mem_oe_n, mem_we_n, mem_pwe_n}), 64'h7);
    chk(req_ready == rdy_exp, {tag, " R2 req_ready"}, 64'(req_ready), 64'(rdy_exp));
    chk(!mem_wdata_en, {tag, " R11 data drive off"}, 64'(mem_wdata_en), 64'h0);
  endtask

  task automatic access(input int cs, input logic [25:0] a, input int sz, input bit wr,
                        input logic [31:0] wd, input logic [31:0] pat, input int z);
    int L, R, S;
    logic [25:0] ea;
    logic [3:0]  ebe;
    logic [31:0] erd;
    S = stb[cs] + 1;
    L = (kind[cs] == 2) ? ((S > z + 1) ? S : z + 1) : S;
    R = rcv[cs];
    ea = a; ebe = 4'b0000;
    if (!wr) begin
      ea[0] = 1'b0;
      if (wide[cs] != 0) ea[1] = 1'b0;
    end else if (wide[cs] != 0) begin
      if (sz == 0) ebe = 4'hF & ~(4'h1 << a[1:0]);
      else if (sz == 1) ebe = a[1] ? 4'b0011 : 4'b1100;
    end else begin
      ebe = (sz == 0) ? (a[0] ? 4'b1101 : 4'b1110) : 4'b1100;
    end
    erd = (wide[cs] != 0) ? pat : (pat & 32'h0000FFFF);
    req_cs = 3'(cs); req_addr = a; req_size = 2'(sz); req_write = wr;
    req_wdata = wd; mem_rdata = pat; req_valid = 1'b1;
    mem_rdy = (z > 0) ? 1'b0 : 1'b1;
    for (int c = 1; c <= 3 + L + R; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c <= 1 + L) begin
        chk(mem_cs_n == ~(6'h1 << cs), "R3 cs select", 64'(mem_cs_n), 64'(~(6'h1 << cs) & 6'h3F));
        chk(req_ready == 1'b0, "R2 no ready while busy", 64'(req_ready), 64'h0);
        chk(mem_addr == ea, wr ? "R8/R9 write address" : "R7 read address", 64'(mem_addr), 64'(ea));
        chk(mem_be_n == ebe, wr ? (wide[cs] != 0 ? "R8 write lanes" : "R9 write lanes") : "R7 read lanes",
            64'(mem_be_n), 64'(ebe));
        chk(mem_wdata_en == wr && (!wr || mem_wdata == wd), "R11 write data",
            64'({mem_wdata_en, mem_wdata}), 64'({wr, wd}));
        if (c == 1)
          chk({mem_oe_n, mem_we_n, mem_pwe_n} == 3'b111, "R2 setup no strobe",
              64'({mem_oe_n, mem_we_n, mem_pwe_n}), 64'h7);
        else
          chk({mem_oe_n, mem_we_n, mem_pwe_n} ==
              {wr, !(wr && kind[cs] != 2), !(wr && kind[cs] == 2)},
              wr ? "R5/R6 write strobe" : "R4/R6 read strobe",
              64'({mem_oe_n, mem_we_n, mem_pwe_n}),
              64'({wr, !(wr && kind[cs] != 2), !(wr && kind[cs] == 2)}));
      end else if (c == 2 + L) begin
        bus_idle("done", 1'b1);
        if (!wr) chk(rsp_rdata == erd, "R10 read data", 64'(rsp_rdata), 64'(erd));
      end else begin
        bus_idle("recovery/idle", 1'b0);
      end
      if (c == 3 + L) req_valid = 1'b0;
      mem_rdy = ((c - 1) > z) ? 1'b1 : 1'b0;
    end
    mem_rdy = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 6; i++) begin
      cfg_kind[2*i +: 2]   = 2'(kind[i]);
      cfg_wide[i]          = (wide[i] != 0);
      cfg_strobe[4*i +: 4] = 4'(stb[i]);
      cfg_recov[4*i +: 4]  = 4'(rcv[i]);
    end
    repeat (3) @(negedge clk);
    bus_idle("R1 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 4; o++)
      access(1, 26'h0123450 + 26'(o), 0, 1'b1, 32'hA1B2C3D4, 32'h0, 0);
    access(1, 26'h0000102, 1, 1'b1, 32'h11223344, 32'h0, 0);
    access(1, 26'h0000100, 1, 1'b1, 32'h55667788, 32'h0, 0);
    access(1, 26'h0000104, 2, 1'b1, 32'hDEADBEEF, 32'h0, 0);
    access(1, 26'h3FFFFFF, 2, 1'b0, 32'h0, 32'hCAFEF00D, 0);
    access(2, 26'h0000201, 0, 1'b1, 32'h0000AB00, 32'h0, 0);
    access(2, 26'h0000200, 0, 1'b1, 32'h000000CD, 32'h0, 0);
    access(2, 26'h0000202, 1, 1'b1, 32'h00001234, 32'h0, 0);
    access(2, 26'h0000203, 1, 1'b0, 32'h0, 32'h9876ABCD, 0);
    access(3, 26'h0000310, 2, 1'b1, 32'h0BADF00D, 32'h0, 4);
    access(3, 26'h0000313, 1, 1'b0, 32'h0, 32'h13579BDF, 5);
    access(4, 26'h0000401, 0, 1'b1, 32'h00003300, 32'h0, 3);
    access(4, 26'h0000405, 1, 1'b0, 32'h0, 32'hFFFF2468, 0);
    access(0, 26'h0000012, 2, 1'b0, 32'h0, 32'h2468ACE0, 50);
    access(5, 26'h0000502, 0, 1'b1, 32'h00EE0000, 32'h0, 0);
    access(5, 26'h0000503, 0, 1'b0, 32'h0, 32'h76543210, 0);
    access(0, 26'h0000020, 0, 1'b1, 32'h77000000, 32'h0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule